// File: doc/BRIEF.md
# Programmable Handler Signal Interface

This block connects test-control logic to an external part handler or wafer prober. Three handler lines come in: start, retest and alarm. Each passes through a two-stage synchronizer and is mapped to an active-high form by one shared input polarity. The block then emits a single-cycle pulse on each assertion edge.

When the tester reports a finished test, the block opens a one-second timing window counted in milliseconds. A millisecond tick is divided down from the system clock. Inside that window, the block drives a 12-line bin code and an end-of-sequence strobe. Each of the two has its own assert and release times and its own output polarity. A retest output mirrors a software control bit and uses the input polarity. A small write-only register port loads the polarities, the four timing values and the bin code.

Top module: `handler_if_top`

## Requirements
- R1: After reset all three polarities are active-low (a polarity bit of 0 means active-low), so bin_o reads all ones, eos_o and retest_o read 1, and all three edge pulses are 0.
- R2: Config register address 0, bit 0 selects the polarity of all three handler inputs together: 1 means active-high, 0 means active-low.
- R3: An input change driven before a clock edge gives a one-cycle pulse on the matching output after the second following edge. Holding the asserted level or releasing it gives no further pulse.
- R4: test_done_i opens a window. The millisecond count is floor(cycles since the capturing edge / PRESCALE), and the window closes after 1000 ms. A bin line whose latched code bit is 1 is asserted while the count is at least the bin start value (address 1) and below the bin stop value (address 2).
- R5: The strobe is asserted while the count is at least the strobe start value (address 3) and below the strobe stop value (address 4). These values are independent of the bin timing, so the strobe may lead, trail or overlap the bin pulse.
- R6: When a stop value is less than or equal to its start value, that output is never asserted.
- R7: Config bit 1 sets the bin polarity and config bit 2 sets the strobe polarity, independently: 1 means active-high.
- R8: retest_o shows config bit 3 as asserted when the bit is 1, at the polarity chosen by config bit 0.
- R9: The bin code written at address 5 is captured at test_done_i. Writes made while the window is open do not change bin_o.
- R10: A test_done_i during an open window restarts the count from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| test_done_i | input | 1 | Test-finished event, one cycle |
| hnd_start_i | input | 1 | Raw handler start line |
| hnd_retest_i | input | 1 | Raw handler retest line |
| hnd_alarm_i | input | 1 | Raw handler alarm line |
| start_pulse_o | output | 1 | Start assertion pulse |
| retest_pulse_o | output | 1 | Retest assertion pulse |
| alarm_pulse_o | output | 1 | Alarm assertion pulse |
| bin_o | output | 12 | Bin lines at bin polarity |
| eos_o | output | 1 | End-of-sequence strobe at its polarity |
| retest_o | output | 1 | Retest echo at input polarity |

## Verification
The windowed outputs are compared on every cycle of each full window against an arithmetic model of the millisecond count. The timing pairs used are: a full-width pulse; a one-millisecond pulse at the start of the window and another at its end; strobe-before-bin, strobe-after-bin and overlapping placements; pairs with an equal or inverted start and stop; and a start time past the window. Together these show where each edge falls and that the window closes. All four polarity combinations appear across the runs, which exposes a swapped or shared phase bit. A bin-code write inside the window separates a latched code from a live one. A second done event in mid-window separates a restart from a continuing count. The handler inputs are exercised under both input polarities, with assert, hold and release on each line, so the tests catch a wrong edge sense, a repeated pulse and a crossed input.

// File: rtl/hif_pkg.sv
package hif_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned N_IN   = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG      = 3'd0,
    REG_BIN_ON   = 3'd1,
    REG_BIN_OFF  = 3'd2,
    REG_EOS_ON   = 3'd3,
    REG_EOS_OFF  = 3'd4,
    REG_BIN_CODE = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic rt_ctrl;
    logic eos_hi;
    logic bin_hi;
    logic in_hi;
  } cfg_t;
endpackage

// File: rtl/hif_in_sync.sv
module hif_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic active_high_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic act, act_q;

  // idle raw level of the reset polarity (active-low) is 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], raw_i};
  end

  assign act = active_high_i ? sync_q[STAGES-1] : ~sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;
  end

  assign rise_o = act & ~act_q;
endmodule

// File: rtl/hif_ms_timer.sv
module hif_ms_timer #(
  parameter int unsigned PRESCALE  = 250000,
  parameter int unsigned WINDOW_MS = 1000,
  parameter int unsigned MS_W      = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  output logic            active_o,
  output logic [MS_W-1:0] ms_o
);
  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(WINDOW_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic             tick;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= '0;
      ms_o     <= '0;
      active_o <= 1'b0;
    end else if (restart_i) begin
      pre_q    <= '0;
      ms_o     <= '0;
      active_o <= 1'b1;
    end else if (active_o) begin
      if (tick) begin
        pre_q <= '0;
        if (ms_o == MS_LAST) active_o <= 1'b0;
        else                 ms_o     <= ms_o + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hif_window.sv
module hif_window #(
  parameter int unsigned MS_W = 10
) (
  input  logic            active_i,
  input  logic [MS_W-1:0] ms_i,
  input  logic [MS_W-1:0] start_i,
  input  logic [MS_W-1:0] stop_i,
  output logic            on_o
);
  // half-open interval; stop <= start yields empty
  assign on_o = active_i && (ms_i >= start_i) && (ms_i < stop_i);
endmodule

// File: rtl/handler_if_top.sv
module handler_if_top
  import hif_pkg::*;
#(
  parameter int unsigned NUM_BINS    = 12,
  parameter int unsigned MS_W        = 10,
  parameter int unsigned WINDOW_MS   = 1000,
  parameter int unsigned PRESCALE    = 250000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_addr_i,
  input  logic [15:0]         wr_data_i,
  input  logic                test_done_i,
  input  logic                hnd_start_i,
  input  logic                hnd_retest_i,
  input  logic                hnd_alarm_i,
  output logic                start_pulse_o,
  output logic                retest_pulse_o,
  output logic                alarm_pulse_o,
  output logic [11:0]         bin_o,
  output logic                eos_o,
  output logic                retest_o
);
  cfg_t                cfg_q;
  logic [MS_W-1:0]     bin_start, bin_stop, eos_start, eos_stop;
  logic [NUM_BINS-1:0] bin_code_r, bin_code_q;
  logic                win_active;
  logic [MS_W-1:0]     ms_cnt;
  logic                bin_on, eos_on;
  logic [N_IN-1:0]     raw_in, rise;
  logic [NUM_BINS-1:0] bin_asrt;

  // register port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      bin_start  <= '0;
      bin_stop   <= '0;
      eos_start  <= '0;
      eos_stop   <= '0;
      bin_code_r <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        REG_CFG:      cfg_q      <= cfg_t'(wr_data_i[$bits(cfg_t)-1:0]);
        REG_BIN_ON:   bin_start  <= wr_data_i[MS_W-1:0];
        REG_BIN_OFF:  bin_stop   <= wr_data_i[MS_W-1:0];
        REG_EOS_ON:   eos_start  <= wr_data_i[MS_W-1:0];
        REG_EOS_OFF:  eos_stop   <= wr_data_i[MS_W-1:0];
        REG_BIN_CODE: bin_code_r <= wr_data_i[NUM_BINS-1:0];
        default: ;
      endcase
    end
  end

  // bin code frozen for the whole window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          bin_code_q <= '0;
    else if (test_done_i) bin_code_q <= bin_code_r;
  end

  // handler inputs
  assign raw_in = {hnd_alarm_i, hnd_retest_i, hnd_start_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    hif_in_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .raw_i         (raw_in[g]),
      .active_high_i (cfg_q.in_hi),
      .rise_o        (rise[g])
    );
  end

  assign start_pulse_o  = rise[0];
  assign retest_pulse_o = rise[1];
  assign alarm_pulse_o  = rise[2];

  // output timing
  hif_ms_timer #(
    .PRESCALE  (PRESCALE),
    .WINDOW_MS (WINDOW_MS),
    .MS_W      (MS_W)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (test_done_i),
    .active_o  (win_active),
    .ms_o      (ms_cnt)
  );

  hif_window #(.MS_W(MS_W)) i_bin_win (
    .active_i (win_active),
    .ms_i     (ms_cnt),
    .start_i  (bin_start),
    .stop_i   (bin_stop),
    .on_o     (bin_on)
  );

  hif_window #(.MS_W(MS_W)) i_eos_win (
    .active_i (win_active),
    .ms_i     (ms_cnt),
    .start_i  (eos_start),
    .stop_i   (eos_stop),
    .on_o     (eos_on)
  );

  assign bin_asrt = bin_code_q & {NUM_BINS{bin_on}};
  assign bin_o    = cfg_q.bin_hi ? bin_asrt : ~bin_asrt;
  assign eos_o    = cfg_q.eos_hi ? eos_on : ~eos_on;
  assign retest_o = cfg_q.in_hi ? cfg_q.rt_ctrl : ~cfg_q.rt_ctrl;
endmodule

// File: rtl/hif_checker.sv
module hif_checker #(
  parameter int unsigned MS_W     = 10,
  parameter int unsigned NUM_BINS = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                test_done_i,
  input logic                win_active,
  input logic [MS_W-1:0]     ms_cnt,
  input logic                bin_on,
  input logic                eos_on,
  input logic [MS_W-1:0]     bin_start,
  input logic [MS_W-1:0]     bin_stop,
  input logic                start_pulse,
  input logic [NUM_BINS-1:0] bin_code_q
);
  // R3
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pulse |=> !start_pulse);

  // R4
  idle_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_active |-> (!bin_on && !eos_on));

  // R6
  empty_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin_stop <= bin_start) |-> !bin_on);

  // R9
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_done_i |=> $stable(bin_code_q));

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_done_i |=> (win_active && ms_cnt == '0));
endmodule

bind handler_if_top hif_checker #(.MS_W(MS_W), .NUM_BINS(NUM_BINS)) i_hif_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .test_done_i (test_done_i),
  .win_active  (win_active),
  .ms_cnt      (ms_cnt),
  .bin_on      (bin_on),
  .eos_on      (eos_on),
  .bin_start   (bin_start),
  .bin_stop    (bin_stop),
  .start_pulse (start_pulse_o),
  .bin_code_q  (bin_code_q)
);

// File: tb/test_handler_if_top.sv
module test_handler_if_top;
  localparam int P   = 2;
  localparam int WIN = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        done = 1'b0;
  logic [2:0]  raw = 3'b111;
  logic        start_p, retest_p, alarm_p, eos, retest;
  logic [11:0] bin;
  logic [3:0]  cfg_s = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  handler_if_top #(.PRESCALE(P)) i_handler_if_top (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .wr_en_i        (wr_en),
    .wr_addr_i      (wr_addr),
    .wr_data_i      (wr_data),
    .test_done_i    (done),
    .hnd_start_i    (raw[0]),
    .hnd_retest_i   (raw[1]),
    .hnd_alarm_i    (raw[2]),
    .start_pulse_o  (start_p),
    .retest_pulse_o (retest_p),
    .alarm_pulse_o  (alarm_p),
    .bin_o          (bin),
    .eos_o          (eos),
    .retest_o       (retest)
  );

  function automatic logic [2:0] pulses();
    return {alarm_p, retest_p, start_p};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fire_done();
    done = 1'b1;
    @(posedge clk); @(negedge clk);
    done = 1'b0;
  endtask

  // assert one input, then hold and release it
  task automatic in_test(int idx, bit hi, string req);
    logic [2:0] exp_p;
    int extra;
    exp_p = 3'b001 << idx;
    raw[idx] = hi;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(pulses() == exp_p, req, "edge pulse", pulses(), exp_p);
    extra = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (pulses() != 0) extra++;
    end
    chk(extra == 0, "R3", "pulse while held", extra, 0);
    raw[idx] = ~hi;
    extra = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pulses() != 0) extra++;
    end
    chk(extra == 0, "R3", "pulse on release", extra, 0);
  endtask

  task automatic run_window(int bst, int bsp, int est, int esp, logic [11:0] code,
                            bit bph, bit eph, bit mid_write, bit restart,
                            string breq, string ereq);
    int b_err, e_err;
    logic [11:0] b_act, b_exp;
    logic e_act, e_exp;
    cfg_s[1] = bph; cfg_s[2] = eph;
    wr(3'd0, {12'd0, cfg_s});
    wr(3'd1, 16'(bst)); wr(3'd2, 16'(bsp));
    wr(3'd3, 16'(est)); wr(3'd4, 16'(esp));
    wr(3'd5, {4'd0, code});
    if (restart) begin
      fire_done();
      repeat (600) @(negedge clk);
    end
    fire_done();
    b_err = 0; e_err = 0; b_act = '0; b_exp = '0; e_act = 0; e_exp = 0;
    for (int c = 0; c < WIN * P + 4; c++) begin
      bit bon, eon;
      logic [11:0] ba, be;
      logic ee;
      bon = (c < WIN * P) && (c / P >= bst) && (c / P < bsp);
      eon = (c < WIN * P) && (c / P >= est) && (c / P < esp);
      ba = bon ? code : 12'd0;
      be = bph ? ba : ~ba;
      ee = eph ? eon : ~eon;
      if (bin !== be) begin
        if (b_err == 0) begin b_act = bin; b_exp = be; end
        b_err++;
      end
      if (eos !== ee) begin
        if (e_err == 0) begin e_act = eos; e_exp = ee; end
        e_err++;
      end
      if (mid_write && c == 100) wr(3'd5, {4'd0, ~code});
      else @(negedge clk);
    end
    chk(b_err == 0, breq, "bin window", b_act, b_exp);
    chk(e_err == 0, ereq, "eos window", e_act, e_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bin === 12'hFFF, "R1", "bin idle", bin, 12'hFFF);
    chk(eos === 1'b1, "R1", "eos idle", eos, 1);
    chk(retest === 1'b1, "R1", "retest idle", retest, 1);
    chk(pulses() === 3'b000, "R1", "pulses idle", pulses(), 0);

    // R2: active-low inputs
    for (int i = 0; i < 3; i++) in_test(i, 1'b0, "R2 low R3");
    // R8 at low polarity
    cfg_s[3] = 1'b1; wr(3'd0, {12'd0, cfg_s});
    chk(retest === 1'b0, "R8", "retest low set", retest, 0);
    cfg_s[3] = 1'b0; wr(3'd0, {12'd0, cfg_s});
    chk(retest === 1'b1, "R8", "retest low clr", retest, 1);

    // switch to active-high: park raw low first
    raw = 3'b000;
    repeat (4) @(negedge clk);
    cfg_s[0] = 1'b1; wr(3'd0, {12'd0, cfg_s});
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) in_test(i, 1'b1, "R2 high R3");
    cfg_s[3] = 1'b1; wr(3'd0, {12'd0, cfg_s});
    chk(retest === 1'b1, "R8", "retest high set", retest, 1);
    cfg_s[3] = 1'b0; wr(3'd0, {12'd0, cfg_s});
    chk(retest === 1'b0, "R8", "retest high clr", retest, 0);

    // windows
    run_window(0, 1000, 0, 1, 12'hA5A, 0, 0, 0, 0, "R4 full", "R5 first ms");
    run_window(5, 6, 3, 900, 12'h3C1, 1, 0, 0, 0, "R4 R7 short", "R5 R7 overlap");
    run_window(998, 999, 999, 1000, 12'hFFF, 0, 1, 0, 0, "R4 R7 late", "R5 R7 after");
    run_window(300, 700, 100, 400, 12'h0F3, 1, 1, 1, 0, "R9 mid write", "R5 R7 lead");
    run_window(10, 10, 20, 5, 12'hFFF, 1, 1, 0, 0, "R6 equal", "R6 inverted");
    run_window(1000, 1023, 0, 1023, 12'h801, 1, 0, 0, 0, "R4 beyond", "R4 R5 close");
    run_window(0, 1000, 0, 500, 12'h555, 1, 1, 0, 1, "R10 bin", "R10 eos");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule